// File: doc/BRIEF.md
# Periodic interrupt request synchronizer

This block raises the processor interrupt on behalf of a motion interpolator that wants fresh velocity data once per millisecond. A free-running divider produces a one-cycle tick every `CLK_HZ/1000` clock cycles. Each tick can arm a request, but only while a software-controlled enable is on. Software turns the enable on by writing a particular control register and off by reading that same register. An armed request is promoted to a synchronized request on the next rising edge of the processor's instruction-fetch-start strobe. The active-low interrupt line is driven only while the fetch-start strobe is high and the request is both armed and synchronized. An interrupt acknowledge from the processor returns the request logic to idle.

Two small state machines hold the state. The enable machine has the states `EN_OFF` and `EN_ON`. The write strobe moves it from `EN_OFF` to `EN_ON`. The read strobe moves it from `EN_ON` to `EN_OFF`, and power-up reset also forces `EN_OFF`. The request machine has the states `RQ_IDLE`, `RQ_ARMED` and `RQ_SYNCED`:
- `RQ_IDLE` goes to `RQ_ARMED` on a tick while the enable is on.
- `RQ_ARMED` goes to `RQ_SYNCED` on a fetch-start rising edge.
- `RQ_SYNCED` holds its state.
- Acknowledge takes any state back to `RQ_IDLE`, and so does power-up reset.

All logic runs on a single clock. Power-up reset is asynchronous and active high.

Top module: `periodic_irq_sync`

## Requirements
- R1: The divider emits one tick every `TICK_CYCLES = CLK_HZ/1000` cycles. Counting rising clock edges after reset is released, a tick is sampled by the request machine at edges TICK_CYCLES, 2*TICK_CYCLES, and so on.
- R2: Asserting `pwr_rst` at once (without waiting for a clock edge) does all of the following: turns the enable off, clears `req_pending` and `req_synced`, and drives `int_n` high.
- R3: A one-cycle `reg15_wr` pulse turns the enable on from the next edge.
- R4: A `reg15_rd` pulse turns the enable off from the next edge. When both strobes are high in the same cycle, the enable ends up off.
- R5: A tick moves the request from `RQ_IDLE` to `RQ_ARMED` (`req_pending`=1) at that edge only if the enable is on. A tick while the enable is off has no effect.
- R6: A rising edge of `fetch_start` in `RQ_ARMED` moves the request to `RQ_SYNCED` (`req_synced`=1) at the next edge. A level that stays high produces no further edge.
- R7: `int_n` is 0 exactly when `fetch_start` is 1 and the request is in `RQ_SYNCED`. Otherwise it is 1.
- R8: `irq_ack` high at an edge returns the request to `RQ_IDLE` from either `RQ_ARMED` or `RQ_SYNCED`. It has priority over a tick and over a fetch-start edge in the same cycle.
- R9: A tick arriving while the request is in `RQ_ARMED` or `RQ_SYNCED` is not stored. After one acknowledge the request is idle, with no second request queued.
- R10: A fetch-start rising edge while the request is in `RQ_IDLE` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pwr_rst | input | 1 | Power-up reset, asynchronous, active high |
| reg15_wr | input | 1 | Decoded write strobe of the enable register |
| reg15_rd | input | 1 | Decoded read strobe of the enable register |
| fetch_start | input | 1 | Instruction-fetch-start strobe from the processor |
| irq_ack | input | 1 | Interrupt acknowledge from the processor |
| int_n | output | 1 | Interrupt to the processor, active low |
| req_pending | output | 1 | Request armed (state `RQ_ARMED` or `RQ_SYNCED`) |
| req_synced | output | 1 | Request aligned to fetch timing (state `RQ_SYNCED`) |

## Verification
Errors in the request machine show up on `req_pending` and `req_synced` one edge after the tick, fetch edge or acknowledge that should have moved them. Errors in the combinational gating show up on `int_n` within the same cycle that `fetch_start` changes. A wrong enable state cannot be seen directly. It becomes visible at the next tick, up to `TICK_CYCLES` cycles later, as a request that should or should not have been armed. For that reason the stimulus always waits through a full tick period after each enable change. A divider that runs fast or slow moves the rise of `req_pending` off the expected edge, which the per-cycle comparison catches.

// File: rtl/irqs_pkg.sv
package irqs_pkg;

    typedef enum logic {
        EN_OFF = 1'b0,
        EN_ON  = 1'b1
    } en_state_t;

    typedef enum logic [1:0] {
        RQ_IDLE   = 2'd0,
        RQ_ARMED  = 2'd1,
        RQ_SYNCED = 2'd2
    } rq_state_t;

endpackage

// File: rtl/ms_tick_gen.sv
module ms_tick_gen #(
    parameter int unsigned CLK_HZ = 1_000_000
) (
    input  logic clk,
    input  logic pwr_rst,
    output logic tick
);
    localparam int unsigned TICK_CYCLES = CLK_HZ / 1000;
    localparam int unsigned CNT_W       = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST   = CNT_W'(TICK_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or posedge pwr_rst) begin
        if (pwr_rst) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign tick = (cnt_q == LAST);

    // R1
    tick_single_chk: assert property (@(posedge clk) disable iff (pwr_rst)
        tick |=> !tick);

endmodule

// File: rtl/rise_detect.sv
module rise_detect (
    input  logic clk,
    input  logic pwr_rst,
    input  logic level,
    output logic pulse
);
    logic prev_q;

    always_ff @(posedge clk or posedge pwr_rst) begin
        if (pwr_rst) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= level;
        end
    end

    assign pulse = level & ~prev_q;

    // R6
    pulse_edge_chk: assert property (@(posedge clk) disable iff (pwr_rst)
        pulse |=> !pulse);

endmodule

// File: rtl/irq_enable_latch.sv
module irq_enable_latch
    import irqs_pkg::*;
(
    input  logic clk,
    input  logic pwr_rst,
    input  logic set_strb,
    input  logic clr_strb,
    output logic enabled
);
    en_state_t state_q, state_d;

    always_ff @(posedge clk or posedge pwr_rst) begin
        if (pwr_rst) begin
            state_q <= EN_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EN_OFF: if (set_strb && !clr_strb) state_d = EN_ON;
            EN_ON:  if (clr_strb)              state_d = EN_OFF;
            default:                           state_d = EN_OFF;
        endcase
    end

    always_comb begin
        enabled = (state_q == EN_ON);
    end

    // R4
    rd_off_chk: assert property (@(posedge clk) disable iff (pwr_rst)
        clr_strb |=> !enabled);

    // R3
    wr_on_chk: assert property (@(posedge clk) disable iff (pwr_rst)
        (set_strb && !clr_strb) |=> enabled);

endmodule

// File: rtl/irq_request_fsm.sv
module irq_request_fsm
    import irqs_pkg::*;
(
    input  logic clk,
    input  logic pwr_rst,
    input  logic tick,
    input  logic enabled,
    input  logic fetch_pulse,
    input  logic ack,
    output logic pending,
    output logic synced
);
    rq_state_t state_q, state_d;

    always_ff @(posedge clk or posedge pwr_rst) begin
        if (pwr_rst) begin
            state_q <= RQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (ack) begin
            state_d = RQ_IDLE;
        end else begin
            unique case (state_q)
                RQ_IDLE:   if (tick && enabled) state_d = RQ_ARMED;
                RQ_ARMED:  if (fetch_pulse)     state_d = RQ_SYNCED;
                RQ_SYNCED:                      state_d = RQ_SYNCED;
                default:                        state_d = RQ_IDLE;
            endcase
        end
    end

    always_comb begin
        pending = (state_q != RQ_IDLE);
        synced  = (state_q == RQ_SYNCED);
    end

    // R8
    ack_idle_chk: assert property (@(posedge clk) disable iff (pwr_rst)
        ack |=> !pending);

    // R5
    arm_cause_chk: assert property (@(posedge clk) disable iff (pwr_rst)
        $rose(pending) |-> $past(tick && enabled));

    // R6
    sync_cause_chk: assert property (@(posedge clk) disable iff (pwr_rst)
        $rose(synced) |-> $past(fetch_pulse));

    // R9
    hold_one_chk: assert property (@(posedge clk) disable iff (pwr_rst)
        (pending && tick && !ack) |=> pending);

endmodule

// File: rtl/periodic_irq_sync.sv
module periodic_irq_sync #(
    parameter int unsigned CLK_HZ = 1_000_000
) (
    input  logic clk,
    input  logic pwr_rst,
    input  logic reg15_wr,
    input  logic reg15_rd,
    input  logic fetch_start,
    input  logic irq_ack,
    output logic int_n,
    output logic req_pending,
    output logic req_synced
);
    logic ms_tick;
    logic fetch_pulse;
    logic irq_enabled;

    ms_tick_gen #(.CLK_HZ(CLK_HZ)) u_tick (
        .clk     (clk),
        .pwr_rst (pwr_rst),
        .tick    (ms_tick)
    );

    rise_detect u_fetch_edge (
        .clk     (clk),
        .pwr_rst (pwr_rst),
        .level   (fetch_start),
        .pulse   (fetch_pulse)
    );

    irq_enable_latch u_enable (
        .clk      (clk),
        .pwr_rst  (pwr_rst),
        .set_strb (reg15_wr),
        .clr_strb (reg15_rd),
        .enabled  (irq_enabled)
    );

    irq_request_fsm u_request (
        .clk         (clk),
        .pwr_rst     (pwr_rst),
        .tick        (ms_tick),
        .enabled     (irq_enabled),
        .fetch_pulse (fetch_pulse),
        .ack         (irq_ack),
        .pending     (req_pending),
        .synced      (req_synced)
    );

    assign int_n = ~(fetch_start & req_synced & req_pending);

    // R7
    intn_needs_fetch_chk: assert property (@(posedge clk) disable iff (pwr_rst)
        !int_n |-> (fetch_start && req_synced));

endmodule

// File: tb/periodic_irq_sync_tb.sv
module periodic_irq_sync_tb;
    localparam int CLK_PERIOD = 10;
    localparam int unsigned TB_HZ = 8000;
    localparam int P = 8;
    localparam int NVEC = 59;

    // {wr, rd, fs, ack, exp_pending, exp_synced, exp_int_n}
    localparam logic [6:0] VEC [NVEC] = '{
        7'b1000_001, 7'b0000_001, 7'b0000_001, 7'b0000_001, 7'b0000_001,
        7'b0000_001, 7'b0000_001, 7'b0000_101, 7'b0010_110, 7'b0000_111,
        7'b0010_110, 7'b0011_001, 7'b0000_001, 7'b0100_001, 7'b0000_001,
        7'b0000_001, 7'b0010_001, 7'b1000_001, 7'b1100_001, 7'b0000_001,
        7'b0000_001, 7'b0000_001, 7'b0000_001, 7'b0000_001, 7'b1000_001,
        7'b0000_001, 7'b0000_001, 7'b0000_001, 7'b0000_001, 7'b0000_001,
        7'b0000_001, 7'b0000_101, 7'b0010_110, 7'b0011_001, 7'b0010_001,
        7'b0000_001, 7'b0000_001, 7'b0000_001, 7'b0000_001, 7'b0000_101,
        7'b0001_001, 7'b0000_001, 7'b0000_001, 7'b0000_001, 7'b0000_001,
        7'b0000_001, 7'b0000_001, 7'b0000_101, 7'b0000_101, 7'b0000_101,
        7'b0000_101, 7'b0000_101, 7'b0000_101, 7'b0000_101, 7'b0000_101,
        7'b0000_101, 7'b0010_110, 7'b0001_001, 7'b0000_001
    };

    logic clk = 1'b0;
    logic pwr_rst = 1'b1;
    logic reg15_wr = 1'b0, reg15_rd = 1'b0, fetch_start = 1'b0, irq_ack = 1'b0;
    logic int_n, req_pending, req_synced;
    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 1'b0;

    periodic_irq_sync #(.CLK_HZ(TB_HZ)) u_dut (
        .clk         (clk),
        .pwr_rst     (pwr_rst),
        .reg15_wr    (reg15_wr),
        .reg15_rd    (reg15_rd),
        .fetch_start (fetch_start),
        .irq_ack     (irq_ack),
        .int_n       (int_n),
        .req_pending (req_pending),
        .req_synced  (req_synced)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 5000 && !done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<=5000", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic check3(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s {pend,sync,int_n} actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic step(input logic wr, input logic rd, input logic fs, input logic ack);
        reg15_wr = wr; reg15_rd = rd; fetch_start = fs; irq_ack = ack;
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic string req_of(input int i);
        case (i)
            0, 24:             return "R3";
            7, 31, 39, 47:     return "R1 R5";
            8, 10, 32, 56:     return "R6 R7";
            11, 33, 40, 57:    return "R8";
            13, 18:            return "R4";
            15, 23:            return "R5";
            16, 34:            return "R10";
            55:                return "R9";
            default:           return "R7";
        endcase
    endfunction

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R2: reset state
        check3("R2", {req_pending, req_synced, int_n}, 3'b001);
        pwr_rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3]);
            check3(req_of(i), {req_pending, req_synced, int_n}, VEC[i][2:0]);
        end

        // R2: reset asserted again clears the enable; no arm at the next tick
        pwr_rst = 1'b1;
        fetch_start = 1'b1;
        #1;
        check3("R2", {req_pending, req_synced, int_n}, 3'b001);
        @(negedge clk);
        pwr_rst = 1'b0;
        for (int i = 0; i < P; i++) step(1'b0, 1'b0, 1'b0, 1'b0);
        check3("R2 R5", {req_pending, req_synced, int_n}, 3'b001);

        // R1: after enabling, the next tick arms at edge 2*P after release
        step(1'b1, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < P - 2; i++) step(1'b0, 1'b0, 1'b0, 1'b0);
        check3("R1", {req_pending, req_synced, int_n}, 3'b001);
        step(1'b0, 1'b0, 1'b0, 1'b0);
        check3("R1 R5", {req_pending, req_synced, int_n}, 3'b101);

        // R7: synchronized request drives the line low with the strobe
        step(1'b0, 1'b0, 1'b1, 1'b0);
        check3("R7", {req_pending, req_synced, int_n}, 3'b110);

        // R2: asynchronous reset mid-cycle with the strobe still high
        #2;
        pwr_rst = 1'b1;
        #1;
        check3("R2", {req_pending, req_synced, int_n}, 3'b001);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule